// File: doc/BRIEF.md
# Paged DMA Descriptor Chain Builder

This block turns one transfer request into a channel program for a descriptor-driven DMA engine. A request gives a start address, a byte length and a direction flag. The block cuts the buffer at page boundaries and writes one descriptor per clock into a small descriptor store through a plain write port. It then writes a terminating stop entry and pulses `done`. The address is taken as physical. Translation, running the DMA engine and bus mastering happen elsewhere.

A start address in the middle of a page gets special handling. If the buffer crosses the end of its first page, the first descriptor covers only the bytes left in that page. Every later descriptor starts page aligned. Each full page except the final piece uses a "more" command. The final piece uses a "last" command. Before anything is written, the block counts the entries the chain needs. A request that would not fit in the reserved descriptor area raises an error and writes nothing.

Top module: `dma_chain_gen`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `wr_en` are all low.
- R2: Let the in-page offset be the low log2(PAGE_BYTES) address bits. When it is non-zero and the length is greater than PAGE_BYTES minus the offset, entry 0 has a count of PAGE_BYTES minus the offset, the start address, and a "more" command. Address and remaining length then advance by that count.
- R3: While more than one page of length remains, the block writes full-page "more" entries, and each one's address is one page above the previous entry's address (modulo 2^ADDR_W).
- R4: The final data entry carries a "last" command and the remaining length as its count, which is at most PAGE_BYTES. An unaligned request that fits inside its first page, or a zero-length request, gives a single last entry holding the whole length at the start address.
- R5: The command field is 3 bits. With `req_read`=1, "more" is 2 and "last" is 3. With `req_read`=0, "more" is 0 and "last" is 1.
- R6: The stop entry follows the last data entry. Its command is 7, its count is 0 and its address is 0. Entries are written one per clock at indices 0, 1, 2, ..., and the first one appears in the cycle after the start is accepted.
- R7: Every entry has its interrupt, wait and branch fields (2 bits each) at 0, which means "never".
- R8: If the chain would need more than MAX_ENTRIES entries, counting the stop entry, `error` pulses high for one cycle in the cycle after the start. Nothing is written and `busy` stays low.
- R9: A `start` pulse while `busy` is high is ignored. The running chain and its request values are unchanged.
- R10: `done` is high for exactly one cycle, the cycle after the stop entry is written, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| req_addr | input | ADDR_W | Physical start address of the buffer |
| req_len | input | LEN_W | Buffer length in bytes |
| req_read | input | 1 | 1 = device-to-memory (input commands), 0 = output commands |
| busy | output | 1 | A chain is being written |
| done | output | 1 | One-cycle pulse after the stop entry |
| error | output | 1 | One-cycle pulse: request rejected for size |
| wr_en | output | 1 | Descriptor write strobe |
| wr_idx | output | $clog2(MAX_ENTRIES) | Descriptor slot being written |
| wr_cmd | output | 3 | Command code |
| wr_count | output | $clog2(PAGE_BYTES)+1 | Byte count |
| wr_addr | output | ADDR_W | Buffer address of this entry |
| wr_irq | output | 2 | Interrupt condition field |
| wr_wait | output | 2 | Wait condition field |
| wr_branch | output | 2 | Branch condition field |

## Verification
The bench builds the block with an 8-bit address, a 7-bit length, a 16-byte page and a 6-entry limit. With these values it can sweep every in-page offset against every length from 0 to 127. That reaches the aligned, partial-first-page, fits-in-first-page and zero-length cases, and every chain size from two entries up to well past the limit. The same small page also lets a request start near the top of the address space and wrap during the chain. A few runs strobe `start` again in the middle of a chain.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

   // Command codes written into each descriptor
   typedef enum logic [2:0] {
      CMD_OUT_MORE = 3'd0,
      CMD_OUT_LAST = 3'd1,
      CMD_IN_MORE  = 3'd2,
      CMD_IN_LAST  = 3'd3,
      CMD_STOP     = 3'd7
   } dcg_cmd_e;

   // Kind of entry the sequencer is emitting
   typedef enum logic [1:0] {
      K_MORE = 2'd0,
      K_LAST = 2'd1,
      K_STOP = 2'd2
   } dcg_kind_e;

   // Condition encoding for the interrupt, wait and branch fields
   localparam logic [1:0] COND_NEVER = 2'b00;

   function automatic dcg_cmd_e pick_cmd(input logic rd, input dcg_kind_e k);
      case (k)
         K_STOP:  return CMD_STOP;
         K_LAST:  return rd ? CMD_IN_LAST : CMD_OUT_LAST;
         default: return rd ? CMD_IN_MORE : CMD_OUT_MORE;
      endcase
   endfunction

endpackage

// File: rtl/dcg_plan.sv
// Sizes a request: works out whether a partial first entry is needed and
// whether the whole chain (data entries plus stop) fits the descriptor area.
module dcg_plan #(
   parameter int LEN_W       = 24,
   parameter int PAGE_BYTES  = 4096,
   parameter int MAX_ENTRIES = 20
) (
   input  logic [$clog2(PAGE_BYTES)-1:0] off,
   input  logic [LEN_W-1:0]              len,
   output logic                          need_part,
   output logic                          fits
);
   localparam int LOG2P = $clog2(PAGE_BYTES);
   localparam int WW    = ((LEN_W > LOG2P) ? LEN_W : LOG2P) + 2;

   logic [WW-1:0] len_w, head, rest, nfull, total;

   always_comb begin
      len_w     = WW'(len);
      head      = WW'(PAGE_BYTES) - WW'(off);
      need_part = (off != '0) && (len_w > head);
      rest      = need_part ? (len_w - head) : len_w;
      nfull     = (rest == '0) ? '0 : ((rest - WW'(1)) >> LOG2P);
      total     = nfull + WW'(need_part) + WW'(2);
      fits      = (total <= WW'(MAX_ENTRIES));
   end

endmodule

// File: rtl/dcg_seq.sv
// Walks the buffer one entry per clock: partial head, full pages, last, stop.
module dcg_seq
   import dcg_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 24,
   parameter int PAGE_BYTES  = 4096,
   parameter int MAX_ENTRIES = 20
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic [ADDR_W-1:0]              req_addr,
   input  logic [LEN_W-1:0]               req_len,
   input  logic                           req_read,
   input  logic                           need_part,
   input  logic                           fits,
   output logic                           busy,
   output logic                           done,
   output logic                           error,
   output logic                           emit,
   output dcg_kind_e                      kind,
   output logic [$clog2(MAX_ENTRIES)-1:0] idx,
   output logic [ADDR_W-1:0]              cur_addr,
   output logic [$clog2(PAGE_BYTES):0]    cur_count,
   output logic                           rd
);
   localparam int LOG2P = $clog2(PAGE_BYTES);
   localparam int WW    = ((LEN_W > LOG2P) ? LEN_W : LOG2P) + 2;
   localparam int CNT_W = LOG2P + 1;
   localparam int IDX_W = $clog2(MAX_ENTRIES);

   typedef enum logic [1:0] {S_IDLE, S_DATA, S_STOP} st_e;

   st_e              st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WW-1:0]     rem_q;
   logic              part_q, read_q, done_q, err_q;
   logic [IDX_W-1:0]  idx_q;
   logic [CNT_W-1:0]  head, step;

   always_comb begin
      head = CNT_W'(PAGE_BYTES) - CNT_W'(addr_q[LOG2P-1:0]);
      kind = K_STOP;
      step = '0;
      if (st_q == S_DATA) begin
         if (part_q) begin
            kind = K_MORE;
            step = head;
         end else if (rem_q > WW'(PAGE_BYTES)) begin
            kind = K_MORE;
            step = CNT_W'(PAGE_BYTES);
         end else begin
            kind = K_LAST;
            step = rem_q[CNT_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         addr_q <= '0;
         rem_q  <= '0;
         part_q <= 1'b0;
         read_q <= 1'b0;
         idx_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (start) begin
                  if (fits) begin
                     st_q   <= S_DATA;
                     addr_q <= req_addr;
                     rem_q  <= WW'(req_len);
                     part_q <= need_part;
                     read_q <= req_read;
                     idx_q  <= '0;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            S_DATA: begin
               idx_q <= idx_q + IDX_W'(1);
               if (kind == K_MORE) begin
                  addr_q <= addr_q + ADDR_W'(step);
                  rem_q  <= rem_q - WW'(step);
                  part_q <= 1'b0;
               end else begin
                  st_q <= S_STOP;
               end
            end
            S_STOP: begin
               st_q   <= S_IDLE;
               done_q <= 1'b1;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != S_IDLE);
   assign emit      = (st_q != S_IDLE);
   assign done      = done_q;
   assign error     = err_q;
   assign idx       = idx_q;
   assign cur_addr  = addr_q;
   assign cur_count = step;
   assign rd        = read_q;

   // Every full-page entry after the first starts on a page boundary
   AST_MORE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && kind == K_MORE && idx_q != '0) |-> (addr_q[LOG2P-1:0] == '0)); // R3

   // The final data entry never holds more than one page
   AST_LAST_FITS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && kind == K_LAST) |-> (rem_q <= WW'(PAGE_BYTES))); // R4

   // A start while busy leaves the chain's direction untouched
   AST_BUSY_HOLDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(read_q)); // R9

endmodule

// File: rtl/dcg_fmt.sv
// Maps the sequencer's entry into descriptor fields on the write port.
module dcg_fmt
   import dcg_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 13
) (
   input  logic              emit,
   input  dcg_kind_e         kind,
   input  logic              rd,
   input  logic [CNT_W-1:0]  count_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [2:0]        cmd,
   output logic [CNT_W-1:0]  count,
   output logic [ADDR_W-1:0] addr,
   output logic [1:0]        irq,
   output logic [1:0]        wt,
   output logic [1:0]        br
);
   always_comb begin
      cmd   = '0;
      count = '0;
      addr  = '0;
      irq   = COND_NEVER;
      wt    = COND_NEVER;
      br    = COND_NEVER;
      if (emit) begin
         cmd = pick_cmd(rd, kind);
         if (kind != K_STOP) begin
            count = count_in;
            addr  = addr_in;
         end
      end
   end
endmodule

// File: rtl/dma_chain_gen.sv
module dma_chain_gen
   import dcg_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 24,
   parameter int PAGE_BYTES  = 4096,
   parameter int MAX_ENTRIES = 20
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic [ADDR_W-1:0]              req_addr,
   input  logic [LEN_W-1:0]               req_len,
   input  logic                           req_read,
   output logic                           busy,
   output logic                           done,
   output logic                           error,
   output logic                           wr_en,
   output logic [$clog2(MAX_ENTRIES)-1:0] wr_idx,
   output logic [2:0]                     wr_cmd,
   output logic [$clog2(PAGE_BYTES):0]    wr_count,
   output logic [ADDR_W-1:0]              wr_addr,
   output logic [1:0]                     wr_irq,
   output logic [1:0]                     wr_wait,
   output logic [1:0]                     wr_branch
);
   localparam int LOG2P = $clog2(PAGE_BYTES);
   localparam int CNT_W = LOG2P + 1;
   localparam int WW    = ((LEN_W > LOG2P) ? LEN_W : LOG2P) + 2;

   // Elaboration-time parameter checks
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      initial $fatal(1, "PAGE_BYTES must be a power of two >= 2");
   end
   if (MAX_ENTRIES < 2 || MAX_ENTRIES >= (1 << (WW - 1))) begin : g_bad_entries
      initial $fatal(1, "MAX_ENTRIES out of range");
   end
   if (ADDR_W < LOG2P) begin : g_bad_addr
      initial $fatal(1, "ADDR_W must cover the in-page offset");
   end

   logic      need_part, fits, emit, rd;
   dcg_kind_e kind;
   logic [CNT_W-1:0] cur_count;
   logic [ADDR_W-1:0] cur_addr;

   dcg_plan #(
      .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MAX_ENTRIES(MAX_ENTRIES)
   ) u_plan (
      .off(req_addr[LOG2P-1:0]), .len(req_len),
      .need_part(need_part), .fits(fits)
   );

   dcg_seq #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MAX_ENTRIES(MAX_ENTRIES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_addr(req_addr), .req_len(req_len), .req_read(req_read),
      .need_part(need_part), .fits(fits),
      .busy(busy), .done(done), .error(error),
      .emit(emit), .kind(kind), .idx(wr_idx),
      .cur_addr(cur_addr), .cur_count(cur_count), .rd(rd)
   );

   dcg_fmt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fmt (
      .emit(emit), .kind(kind), .rd(rd),
      .count_in(cur_count), .addr_in(cur_addr),
      .cmd(wr_cmd), .count(wr_count), .addr(wr_addr),
      .irq(wr_irq), .wt(wr_wait), .br(wr_branch)
   );

   assign wr_en = emit;

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!done && !error)); // R1

   AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_cmd == CMD_STOP) |=> (done && !busy)); // R10

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (!wr_en && !busy)); // R8

   AST_IDX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_en) |-> (wr_idx == '0)); // R6

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (wr_idx == $past(wr_idx) + 1'b1)); // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < MAX_ENTRIES)); // R8

   AST_COUNT_LE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_count) <= PAGE_BYTES)); // R4

   AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_cmd != CMD_STOP && $past(wr_en) &&
       ($past(wr_cmd) == CMD_IN_MORE || $past(wr_cmd) == CMD_OUT_MORE))
      |-> (wr_addr == $past(wr_addr) + ADDR_W'($past(wr_count)))); // R3

endmodule

// File: tb/sim_dma_chain_gen.sv
`timescale 1ns/1ps
module sim_dma_chain_gen;
   localparam int AW = 8;
   localparam int LW = 7;
   localparam int PB = 16;
   localparam int ME = 6;
   localparam int CW = $clog2(PB) + 1;
   localparam int IW = $clog2(ME);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic req_read = 1'b0;
   logic busy, done, error, wr_en;
   logic [IW-1:0] wr_idx;
   logic [2:0] wr_cmd;
   logic [CW-1:0] wr_count;
   logic [AW-1:0] wr_addr;
   logic [1:0] wr_irq, wr_wait, wr_branch;

   int n_chk = 0;
   int n_fail = 0;

   // expected chain
   int e_n;
   int e_cmd [0:31];
   int e_cnt [0:31];
   int e_adr [0:31];
   string e_tag [0:31];

   always #10 clk = ~clk;

   dma_chain_gen #(.ADDR_W(AW), .LEN_W(LW), .PAGE_BYTES(PB), .MAX_ENTRIES(ME)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_addr(req_addr), .req_len(req_len), .req_read(req_read),
      .busy(busy), .done(done), .error(error),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_cmd(wr_cmd), .wr_count(wr_count),
      .wr_addr(wr_addr), .wr_irq(wr_irq), .wr_wait(wr_wait), .wr_branch(wr_branch)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic push(input int cmd, input int cnt, input int adr, input string tag);
      e_cmd[e_n] = cmd;
      e_cnt[e_n] = cnt;
      e_adr[e_n] = adr & 255;
      e_tag[e_n] = tag;
      e_n++;
   endtask

   // Model built from the requirements
   task automatic model(input int a, input int len, input bit rd);
      int off, rem, cur;
      e_n = 0;
      cur = a;
      rem = len;
      off = a % PB;
      if (off != 0 && rem > PB - off) begin
         push(rd ? 2 : 0, PB - off, cur, "R2");
         cur = (cur + PB - off) & 255;
         rem = rem - (PB - off);
      end
      while (rem > PB) begin
         push(rd ? 2 : 0, PB, cur, "R3");
         cur = (cur + PB) & 255;
         rem = rem - PB;
      end
      push(rd ? 3 : 1, rem, cur, "R4");
      push(7, 0, 0, "R6");
   endtask

   // Called at a falling edge; returns at a falling edge
   task automatic run_req(input int a, input int len, input bit rd, input bit poke);
      string tg;
      model(a, len, rd);
      req_addr = AW'(a);
      req_len  = LW'(len);
      req_read = rd;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (e_n > ME) begin
         chk(error === 1'b1, "R8", "error pulse", int'(error), 1);
         chk(wr_en === 1'b0 && busy === 1'b0, "R8", "quiet on reject", int'(wr_en), 0);
         @(negedge clk);
         chk(error === 1'b0 && wr_en === 1'b0, "R8", "error one cycle, no write",
             int'(error) + int'(wr_en), 0);
      end else begin
         for (int i = 0; i < e_n; i++) begin
            tg = poke ? "R9" : e_tag[i];
            chk(wr_en === 1'b1, tg, "write strobe", int'(wr_en), 1);
            chk(int'(wr_idx) == i, "R6", "index", int'(wr_idx), i);
            chk(int'(wr_cmd) == e_cmd[i], (i < e_n - 1) ? "R5" : "R6", "command",
                int'(wr_cmd), e_cmd[i]);
            chk(int'(wr_count) == e_cnt[i] && int'(wr_addr) == e_adr[i], tg,
                "count*256+addr", int'(wr_count) * 256 + int'(wr_addr),
                e_cnt[i] * 256 + e_adr[i]);
            chk(wr_irq == 2'b00 && wr_wait == 2'b00 && wr_branch == 2'b00, "R7",
                "condition fields", int'({wr_irq, wr_wait, wr_branch}), 0);
            if (poke && i == 0) begin
               req_addr = AW'(a ^ 8'h5A);
               req_len  = LW'(3);
               req_read = ~rd;
               start    = 1'b1;
            end
            if (poke && i == 1) start = 1'b0;
            @(negedge clk);
         end
         chk(done === 1'b1 && busy === 1'b0 && wr_en === 1'b0, "R10", "done after stop",
             int'(done), 1);
         @(negedge clk);
         chk(done === 1'b0 && wr_en === 1'b0, poke ? "R9" : "R10", "done one cycle, idle",
             int'(done) + int'(wr_en), 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && error === 1'b0 && wr_en === 1'b0, "R1",
          "outputs in reset", int'({busy, done, error, wr_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && error === 1'b0 && wr_en === 1'b0, "R1",
          "outputs after reset", int'({busy, done, error, wr_en}), 0);

      // Sweep every in-page offset against every length
      for (int off = 0; off < PB; off++) begin
         for (int len = 0; len < (1 << LW); len++) begin
            run_req(8'h30 + off, len, ((off + len) % 2) == 1, 1'b0);
         end
      end

      // Address wrap within a chain
      run_req(8'hF5, 40, 1'b1, 1'b0);
      run_req(8'hE0, 64, 1'b0, 1'b0);

      // Start strobes while busy
      run_req(8'h07, 50, 1'b0, 1'b1);
      run_req(8'h40, 33, 1'b1, 1'b1);
      run_req(8'h3C, 2, 1'b1, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule